// File: doc/BRIEF.md
# Programmable Qualified Event Counter

This block keeps a 48-bit count of hardware activity. The activity it counts is chosen and shaped by one control register. Every clock cycle it receives three kinds of source. The first is a set of cache-lookup lanes, each carrying a line state and a request kind. The second is a set of snoop-response lanes, each carrying a response type and an origin. The third is a tracker occupancy value.

An 8-bit event code picks the source and an 8-bit unit mask filters its lanes. The block adds the number of matching lanes in the cycle, or the occupancy value. It then turns that number into the amount to add. A threshold can turn it into a one-per-cycle condition, an invert bit can flip the threshold test, and an edge bit can count rising edges of the condition. The result goes into the count register.

Software reads and writes both registers through a plain strobe-and-address port. Event lanes are sampled every cycle and are never stalled, so no back-pressure path exists. A source holds each lane only for the single cycle it occurs.

Top module: `qev_counter`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 and cfg_bad is low.
- R2: Code 34h counts valid lookup lanes. A lane matches when its one-hot state (bit 0 M, bit 1 E, bit 2 S, bit 3 I) meets unit-mask bits 3:0 and its one-hot kind (bit 0 read, bit 1 write, bit 2 external snoop, bit 3 any) meets unit-mask bits 7:4; both groups must hit.
- R3: Code 22h counts valid snoop lanes. A lane matches when its 5-bit response type meets unit-mask bits 4:0 and its 3-bit origin meets unit-mask bits 7:5.
- R4: With threshold 0 and edge off, each cycle adds the full event number, whatever the invert bit holds.
- R5: With a nonzero threshold and invert off, a cycle adds 1 when the event number is at or above the threshold, else 0.
- R6: With a nonzero threshold and invert on, a cycle adds 1 when the event number is below the threshold, else 0.
- R7: With edge on, the count rises by 1 in each cycle where the condition (event number nonzero, or the threshold test) is true and was false the cycle before.
- R8: Any control write clears the edge history, so a condition that stays true across the write is counted again.
- R9: Code 80h adds occ_count every cycle and ignores the unit mask.
- R10: While enabled with an unknown code, or with code 80h on an instance whose CTR_INDEX is not 0, cfg_bad is high and the count does not move.
- R11: With the enable bit low, the count does not move.
- R12: A count write holds its value after the write edge. It overrides any increment due in that cycle.
- R13: The count wraps from 2^48-1 to 0 with no flag.
- R14: Address 0 is control: code [7:0], unit mask [15:8], threshold [23:16], edge [24], invert [25], enable [26]. Address 1 is the count. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects count |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr |
| lk_valid | input | NL | Lookup lane valid |
| lk_state | input | 4*NL | One-hot line state per lookup lane |
| lk_kind | input | 4*NL | One-hot request kind per lookup lane |
| sn_valid | input | NS | Snoop lane valid |
| sn_resp | input | 5*NS | One-hot response type per snoop lane |
| sn_src | input | 3*NS | One-hot origin per snoop lane |
| occ_count | input | OCC_W | Valid tracker entries this cycle |
| cfg_bad | output | 1 | Enabled configuration is not supported |

## Verification
A wrong lane match or threshold result changes the count in the same cycle as the stimulus. It can be read back one edge later. A stale edge history shows up as a missing increment on the first qualifying cycle after a control write. A bad validity decode shows up at once on cfg_bad, and as a count that moves when it should stay frozen. A wrong write priority or wrap leaves a count that differs from the expected value by exactly the increment of that cycle.

// File: rtl/qev_pkg.sv
package qev_pkg;
  localparam logic [7:0] CODE_SNOOP  = 8'h22;
  localparam logic [7:0] CODE_LOOKUP = 8'h34;
  localparam logic [7:0] CODE_OCC    = 8'h80;

  typedef struct packed {
    logic       en;
    logic       inv;
    logic       edge_on;
    logic [7:0] cmask;
    logic [7:0] umask;
    logic [7:0] code;
  } qev_ctrl_t;

  localparam int CTRL_W = $bits(qev_ctrl_t);
endpackage

// File: rtl/qev_select.sv
module qev_select
  import qev_pkg::*;
#(
  parameter int NL        = 4,
  parameter int NS        = 4,
  parameter int OCC_W     = 5,
  parameter int EV_W      = 5,
  parameter int CTR_INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qev_ctrl_t         ctrl,
  input  logic [NL-1:0]     lk_valid,
  input  logic [4*NL-1:0]   lk_state,
  input  logic [4*NL-1:0]   lk_kind,
  input  logic [NS-1:0]     sn_valid,
  input  logic [5*NS-1:0]   sn_resp,
  input  logic [3*NS-1:0]   sn_src,
  input  logic [OCC_W-1:0]  occ_count,
  output logic [EV_W-1:0]   evt_n,
  output logic              cfg_bad
);
  logic [NL-1:0] lk_hit;
  logic [NS-1:0] sn_hit;
  logic [EV_W-1:0] lk_sum, sn_sum;
  logic known;

  for (genvar i = 0; i < NL; i++) begin : g_lk
    assign lk_hit[i] = lk_valid[i] &
                       (|(lk_state[i*4 +: 4] & ctrl.umask[3:0])) &
                       (|(lk_kind[i*4 +: 4]  & ctrl.umask[7:4]));
  end

  for (genvar j = 0; j < NS; j++) begin : g_sn
    assign sn_hit[j] = sn_valid[j] &
                       (|(sn_resp[j*5 +: 5] & ctrl.umask[4:0])) &
                       (|(sn_src[j*3 +: 3]  & ctrl.umask[7:5]));
  end

  always_comb begin
    lk_sum = '0;
    for (int i = 0; i < NL; i++) lk_sum = lk_sum + EV_W'(lk_hit[i]);
    sn_sum = '0;
    for (int j = 0; j < NS; j++) sn_sum = sn_sum + EV_W'(sn_hit[j]);
  end

  always_comb begin
    known = 1'b1;
    evt_n = '0;
    case (ctrl.code)
      CODE_LOOKUP: evt_n = lk_sum;
      CODE_SNOOP:  evt_n = sn_sum;
      CODE_OCC: begin
        if (CTR_INDEX == 0) evt_n = EV_W'(occ_count);
        else known = 1'b0;
      end
      default: known = 1'b0;
    endcase
  end

  assign cfg_bad = ctrl.en & ~known;

  // R2
  lookup_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.code == CODE_LOOKUP) |-> (evt_n <= EV_W'(NL)));
endmodule

// File: rtl/qev_qualify.sv
module qev_qualify #(
  parameter int EV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            active,
  input  logic [EV_W-1:0] evt_n,
  input  logic [7:0]      cmask,
  input  logic            inv,
  input  logic            edge_on,
  output logic [EV_W-1:0] inc
);
  localparam int CMP_W = (EV_W > 8) ? EV_W : 8;

  logic [CMP_W-1:0] n_w, c_w;
  logic cond, cond_q, prev_q;

  assign n_w = CMP_W'(evt_n);
  assign c_w = CMP_W'(cmask);

  always_comb begin
    if (cmask == 8'd0) cond = (evt_n != '0);
    else if (inv)      cond = (n_w < c_w);
    else               cond = (n_w >= c_w);
  end

  assign cond_q = active & cond;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) prev_q <= 1'b0;
    else               prev_q <= cond_q;
  end

  always_comb begin
    if (!active)              inc = '0;
    else if (edge_on)         inc = EV_W'(cond_q & ~prev_q);
    else if (cmask == 8'd0)   inc = evt_n;
    else                      inc = EV_W'(cond);
  end

  // R7
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_on && active && inc != '0 && !clr) |=> (inc == '0));

  // R5
  thresh_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmask != 8'd0) |-> (inc <= EV_W'(1)));
endmodule

// File: rtl/qev_counter.sv
module qev_counter
  import qev_pkg::*;
#(
  parameter int NL        = 4,
  parameter int NS        = 4,
  parameter int OCC_W     = 5,
  parameter int CNT_W     = 48,
  parameter int CTR_INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [NL-1:0]     lk_valid,
  input  logic [4*NL-1:0]   lk_state,
  input  logic [4*NL-1:0]   lk_kind,
  input  logic [NS-1:0]     sn_valid,
  input  logic [5*NS-1:0]   sn_resp,
  input  logic [3*NS-1:0]   sn_src,
  input  logic [OCC_W-1:0]  occ_count,
  output logic              cfg_bad
);
  localparam int OCC_MAX = (1 << OCC_W) - 1;
  localparam int LANE_MX = (NL > NS) ? NL : NS;
  localparam int MAXN    = (LANE_MX > OCC_MAX) ? LANE_MX : OCC_MAX;
  localparam int EV_W    = $clog2(MAXN + 1);

  qev_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic [EV_W-1:0]  evt_n, inc;
  logic             wr_ctrl, wr_cnt;

  assign wr_ctrl = reg_wr & ~reg_addr;
  assign wr_cnt  = reg_wr &  reg_addr;

  qev_select #(
    .NL(NL), .NS(NS), .OCC_W(OCC_W), .EV_W(EV_W), .CTR_INDEX(CTR_INDEX)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q),
    .lk_valid(lk_valid), .lk_state(lk_state), .lk_kind(lk_kind),
    .sn_valid(sn_valid), .sn_resp(sn_resp), .sn_src(sn_src),
    .occ_count(occ_count), .evt_n(evt_n), .cfg_bad(cfg_bad)
  );

  qev_qualify #(.EV_W(EV_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctrl),
    .active(ctrl_q.en & ~cfg_bad), .evt_n(evt_n),
    .cmask(ctrl_q.cmask), .inv(ctrl_q.inv), .edge_on(ctrl_q.edge_on),
    .inc(inc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= qev_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wr_cnt)  count_q <= reg_wdata;
      else         count_q <= count_q + CNT_W'(inc);
    end
  end

  assign reg_rdata = reg_addr ? count_q : CNT_W'(ctrl_q);

  // R12
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_q == $past(reg_wdata)));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !ctrl_q.en) |=> (count_q == $past(count_q)));

  // R10
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> (inc == '0));

  // R7
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && ctrl_q.en && ctrl_q.edge_on) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: tb/qev_counter_test.sv
module qev_counter_test;
  localparam int NL = 4, NS = 4, OCC_W = 5, CNT_W = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_wr1 = 1'b0, reg_addr = 1'b1;
  logic [CNT_W-1:0] reg_wdata = '0, reg_rdata, reg_rdata1;
  logic [NL-1:0] lk_valid = '0;
  logic [4*NL-1:0] lk_state = '0, lk_kind = '0;
  logic [NS-1:0] sn_valid = '0;
  logic [5*NS-1:0] sn_resp = '0;
  logic [3*NS-1:0] sn_src = '0;
  logic [OCC_W-1:0] occ_count = '0;
  logic cfg_bad, cfg_bad1;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  qev_counter #(.NL(NL), .NS(NS), .OCC_W(OCC_W), .CNT_W(CNT_W), .CTR_INDEX(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_state(lk_state), .lk_kind(lk_kind),
    .sn_valid(sn_valid), .sn_resp(sn_resp), .sn_src(sn_src),
    .occ_count(occ_count), .cfg_bad(cfg_bad));

  qev_counter #(.NL(NL), .NS(NS), .OCC_W(OCC_W), .CNT_W(CNT_W), .CTR_INDEX(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr1), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata1),
    .lk_valid(lk_valid), .lk_state(lk_state), .lk_kind(lk_kind),
    .sn_valid(sn_valid), .sn_resp(sn_resp), .sn_src(sn_src),
    .occ_count(occ_count), .cfg_bad(cfg_bad1));

  function automatic logic [CNT_W-1:0] mk(input logic en, input logic inv,
      input logic edg, input logic [7:0] cm, input logic [7:0] um, input logic [7:0] code);
    return CNT_W'({en, inv, edg, cm, um, code});
  endfunction

  task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [CNT_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic rd(input logic a, output logic [CNT_W-1:0] v);
    reg_addr = a; #1; v = reg_rdata; reg_addr = 1'b1;
  endtask

  task automatic idle();
    lk_valid = '0; lk_state = '0; lk_kind = '0;
    sn_valid = '0; sn_resp = '0; sn_src = '0; occ_count = '0;
  endtask

  // k lanes valid with state M and kind read
  task automatic lanes(input int k);
    idle();
    for (int i = 0; i < NL; i++) begin
      lk_state[i*4 +: 4] = 4'b0001;
      lk_kind[i*4 +: 4]  = 4'b0001;
      lk_valid[i] = (i < k);
    end
  endtask

  task automatic setup(input logic [CNT_W-1:0] c);
    idle();
    wr(1'b0, c);
    wr(1'b1, '0);
  endtask

  task automatic run_seq(input int a, input int b, input int c, input int d);
    lanes(a); step(); lanes(b); step(); lanes(c); step(); lanes(d); step(); idle();
  endtask

  task automatic t_reset();
    logic [CNT_W-1:0] v;
    rd(1'b1, v); check("R1 count", v, 0);
    rd(1'b0, v); check("R1 ctrl", v, 0);
    check("R1 cfg_bad", CNT_W'(cfg_bad), 0);
  endtask

  task automatic t_lookup();
    logic [CNT_W-1:0] v;
    logic [CNT_W-1:0] c;
    c = mk(1, 0, 0, 0, 8'h13, 8'h34);
    setup(c);
    rd(1'b0, v); check("R14 ctrl readback", v, c);
    lk_valid = 4'b1111;
    lk_state = {4'b1000, 4'b0100, 4'b0010, 4'b0001};
    lk_kind  = {4'b1000, 4'b0001, 4'b0010, 4'b0001};
    step(); step(); idle();
    rd(1'b1, v); check("R2 lookup M|E read", v, 2);
    setup(mk(1, 0, 0, 0, 8'h26, 8'h34));
    lk_valid = 4'b1111;
    lk_state = {4'b1000, 4'b0100, 4'b0010, 4'b0001};
    lk_kind  = {4'b1000, 4'b0001, 4'b0010, 4'b0001};
    step(); idle();
    rd(1'b1, v); check("R2 lookup E|S write", v, 1);
    setup(mk(1, 0, 0, 0, 8'h0F, 8'h34));
    lanes(4); step(); idle();
    rd(1'b1, v); check("R2 no filter bits", v, 0);
  endtask

  task automatic t_snoop();
    logic [CNT_W-1:0] v;
    setup(mk(1, 0, 0, 0, 8'h21, 8'h22));
    sn_valid = 4'b0111;
    sn_resp = {5'b00001, 5'b00010, 5'b00001, 5'b00001};
    sn_src  = {3'b001, 3'b001, 3'b010, 3'b001};
    step(); step(); idle();
    rd(1'b1, v); check("R3 snoop narrow", v, 2);
    setup(mk(1, 0, 0, 0, 8'hE3, 8'h22));
    sn_valid = 4'b0111;
    sn_resp = {5'b00001, 5'b00010, 5'b00001, 5'b00001};
    sn_src  = {3'b001, 3'b001, 3'b010, 3'b001};
    step(); idle();
    rd(1'b1, v); check("R3 snoop wide", v, 3);
  endtask

  task automatic t_qualifiers();
    logic [CNT_W-1:0] v;
    setup(mk(1, 1, 0, 0, 8'h11, 8'h34));
    run_seq(3, 1, 2, 0);
    rd(1'b1, v); check("R4 full count, inv ignored", v, 6);
    setup(mk(1, 0, 0, 8'd2, 8'h11, 8'h34));
    run_seq(3, 1, 2, 0);
    rd(1'b1, v); check("R5 threshold", v, 2);
    setup(mk(1, 1, 0, 8'd2, 8'h11, 8'h34));
    run_seq(3, 1, 2, 0);
    rd(1'b1, v); check("R6 inverted threshold", v, 2);
    setup(mk(1, 0, 1, 0, 8'h11, 8'h34));
    run_seq(1, 2, 0, 3); lanes(3); step(); idle();
    rd(1'b1, v); check("R7 edge count", v, 2);
  endtask

  task automatic t_edge_clear();
    logic [CNT_W-1:0] v;
    logic [CNT_W-1:0] c;
    c = mk(1, 0, 1, 0, 8'h11, 8'h34);
    setup(c);
    lanes(1); step(); step(); step();
    rd(1'b1, v); check("R7 held condition once", v, 1);
    wr(1'b0, c);
    step(); step(); idle();
    rd(1'b1, v); check("R8 history cleared", v, 2);
  endtask

  task automatic t_occ();
    logic [CNT_W-1:0] v;
    setup(mk(1, 0, 0, 0, 8'h5A, 8'h80));
    occ_count = 5; step(); occ_count = 7; step(); idle();
    rd(1'b1, v); check("R9 weighted", v, 12);
    setup(mk(1, 0, 0, 8'd6, 8'h00, 8'h80));
    occ_count = 5; step(); occ_count = 7; step(); occ_count = 9; step(); idle();
    rd(1'b1, v); check("R5 occupancy threshold", v, 2);
    idle();
    reg_wr1 = 1'b1; reg_addr = 1'b0; reg_wdata = mk(1, 0, 0, 0, 8'h00, 8'h80);
    step(); reg_wr1 = 1'b0; reg_addr = 1'b1;
    occ_count = 9; step(); step(); idle();
    check("R10 index1 cfg_bad", CNT_W'(cfg_bad1), 1);
    #1; check("R10 index1 frozen", reg_rdata1, 0);
  endtask

  task automatic t_bad_disable();
    logic [CNT_W-1:0] v;
    setup(mk(1, 0, 0, 0, 8'hFF, 8'h55));
    wr(1'b1, 100);
    check("R10 cfg_bad", CNT_W'(cfg_bad), 1);
    lanes(4); step(); step(); idle();
    rd(1'b1, v); check("R10 frozen", v, 100);
    setup(mk(0, 0, 0, 0, 8'hFF, 8'h34));
    wr(1'b1, 77);
    lanes(4); step(); step(); idle();
    rd(1'b1, v); check("R11 disabled", v, 77);
    check("R11 cfg_bad low", CNT_W'(cfg_bad), 0);
  endtask

  task automatic t_write_wrap();
    logic [CNT_W-1:0] v;
    setup(mk(1, 0, 0, 0, 8'hFF, 8'h34));
    lanes(4);
    wr(1'b1, 1000);
    idle();
    rd(1'b1, v); check("R12 write wins", v, 1000);
    lanes(4); step(); idle();
    rd(1'b1, v); check("R12 counts after", v, 1004);
    wr(1'b1, {CNT_W{1'b1}} - 1);
    lanes(3); step(); idle();
    rd(1'b1, v); check("R13 wrap", v, 1);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_lookup();
    t_snoop();
    t_qualifiers();
    t_edge_clear();
    t_occ();
    t_bad_disable();
    t_write_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule